// File: doc/BRIEF.md
# Filtered Event Performance Counters

This block keeps two independent event counters and one elapsed-cycle counter for a memory controller. The event sources present one pulse per cycle for each of eleven event kinds, together with the connection ID and the chip-select region of the transaction the pulse belongs to. Each counter channel picks one event kind by a 4-bit code. It can also narrow its count to a single requester, to a single region, or to both.

Software programs both channels with a single 32-bit configuration write. That write also restarts all three counters, so the elapsed-cycle counter always gives the window over which the event counts were taken. The counters are read through a small combinational read port selected by a 2-bit address.

Top module: `perf_counters`

## Requirements
- R1: After synchronous reset, both event counters and the elapsed-cycle counter read 0, and the configuration reads 0 (code 0, both filters off).
- R2: A channel with code c in 0..10 adds 1 in each cycle where bit c of `ev_pulse` is high and its filters pass. Codes 11 to 15 never count. Each channel counts independently of the other.
- R3: With the connection-ID filter enabled (channel field bit 4), an event counts only if `ev_conn_id` equals the channel's programmed ID (field bits 15:8).
- R4: With the region filter enabled (channel field bit 5), an event counts only if `ev_region` equals the channel's programmed region (field bits 7:6).
- R5: With both filters enabled, an event counts only when both tags match.
- R6: The elapsed-cycle counter increments by 1 in every cycle without a configuration write.
- R7: A cycle with `cfg_we` high loads `cfg_wdata` and sets all three counters to 0. Events in that cycle are not counted. Channel 0 takes bits 15:0 and channel 1 takes bits 31:16; within each field the code sits at bits 3:0.
- R8: The counters wrap modulo 2^CNT_W, with CNT_W defaulting to 32. Read values are zero-extended to 32 bits.
- R9: `rd_data` combinationally returns channel 0's count for `rd_addr`=0, channel 1's count for 1, the elapsed-cycle count for 2, and the configuration word for 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_pulse | input | 11 | Per-cycle event strobes; bit i is event code i |
| ev_conn_id | input | 8 | Requester connection ID tag of this cycle's events |
| ev_region | input | 2 | Chip-select region tag of this cycle's events |
| cfg_we | input | 1 | Configuration write strobe; also clears the counters |
| cfg_wdata | input | 32 | Configuration word (two 16-bit channel fields) |
| rd_addr | input | 2 | Read select |
| rd_data | output | 32 | Selected counter or configuration value |

## Verification
On every cycle the assertions check the following: a counter either clears or steps by exactly its increment; a channel never counts with an unused code; and any counted event carries the programmed tag whenever a filter is enabled. Only the bench's scenarios can show that the right event bit is selected, that the filters do not drop events that match, that the two channels stay apart, and that a configuration write restarts the window. Wrap-around is shown on a 4-bit instance that runs next to the full-width one.

// File: rtl/perfctr_pkg.sv
package perfctr_pkg;
    localparam int EVT_N  = 11;
    localparam int CODE_W = 4;
    localparam int ID_W   = 8;
    localparam int RGN_W  = 2;
    localparam int DATA_W = 32;
    localparam int CH_N   = 2;

    // One channel's configuration field, 16 bits: code[3:0], id_en[4], rgn_en[5], region[7:6], id[15:8]
    typedef struct packed {
        logic [ID_W-1:0]   conn_id;
        logic [RGN_W-1:0]  region;
        logic              rgn_en;
        logic              id_en;
        logic [CODE_W-1:0] code;
    } ch_cfg_t;

    localparam int CFG_W = $bits(ch_cfg_t);

    typedef enum logic [1:0] {
        RD_CNT0 = 2'd0,
        RD_CNT1 = 2'd1,
        RD_TIME = 2'd2,
        RD_CFG  = 2'd3
    } rd_sel_e;

    function automatic logic code_valid(input logic [CODE_W-1:0] c);
        return int'(c) < EVT_N;
    endfunction
endpackage

// File: rtl/perf_event_filter.sv
module perf_event_filter
    import perfctr_pkg::*;
(
    input  ch_cfg_t            cfg,
    input  logic [EVT_N-1:0]   pulse,
    input  logic [ID_W-1:0]    conn_id,
    input  logic [RGN_W-1:0]   region,
    output logic               hit
);
    logic sel_evt;
    logic id_ok;
    logic rgn_ok;

    always_comb begin
        sel_evt = 1'b0;
        for (int i = 0; i < EVT_N; i++) begin
            if (int'(cfg.code) == i) sel_evt = pulse[i];
        end
        id_ok  = !cfg.id_en  || (conn_id == cfg.conn_id);
        rgn_ok = !cfg.rgn_en || (region  == cfg.region);
        hit    = sel_evt && id_ok && rgn_ok;
    end
endmodule

// File: rtl/perf_count_reg.sv
module perf_count_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (inc)   cnt <= cnt + W'(1);
    end

    // R7
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> cnt == '0);

    // R8
    step_chk: assert property (@(posedge clk) disable iff (rst)
        !clr |=> cnt == $past(cnt) + W'($past(inc)));
endmodule

// File: rtl/perf_counters.sv
module perf_counters
    import perfctr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [EVT_N-1:0]   ev_pulse,
    input  logic [ID_W-1:0]    ev_conn_id,
    input  logic [RGN_W-1:0]   ev_region,
    input  logic               cfg_we,
    input  logic [DATA_W-1:0]  cfg_wdata,
    input  logic [1:0]         rd_addr,
    output logic [DATA_W-1:0]  rd_data
);
    ch_cfg_t          cfg_q [CH_N];
    logic [CH_N-1:0]  hit;
    logic [CNT_W-1:0] cnt   [CH_N];
    logic [CNT_W-1:0] time_cnt;

    generate
        for (genvar ch = 0; ch < CH_N; ch++) begin : g_ch
            always_ff @(posedge clk) begin
                if (rst)         cfg_q[ch] <= '0;
                else if (cfg_we) cfg_q[ch] <= ch_cfg_t'(cfg_wdata[ch*CFG_W +: CFG_W]);
            end

            perf_event_filter u_filt (
                .cfg     (cfg_q[ch]),
                .pulse   (ev_pulse),
                .conn_id (ev_conn_id),
                .region  (ev_region),
                .hit     (hit[ch])
            );

            perf_count_reg #(.W(CNT_W)) u_cnt (
                .clk (clk),
                .rst (rst),
                .clr (cfg_we),
                .inc (hit[ch]),
                .cnt (cnt[ch])
            );

            // R2
            dead_code_chk: assert property (@(posedge clk) disable iff (rst)
                !code_valid(cfg_q[ch].code) |-> !hit[ch]);

            // R3
            id_filter_chk: assert property (@(posedge clk) disable iff (rst)
                (hit[ch] && cfg_q[ch].id_en) |-> ev_conn_id == cfg_q[ch].conn_id);

            // R4
            rgn_filter_chk: assert property (@(posedge clk) disable iff (rst)
                (hit[ch] && cfg_q[ch].rgn_en) |-> ev_region == cfg_q[ch].region);
        end
    endgenerate

    perf_count_reg #(.W(CNT_W)) u_time (
        .clk (clk),
        .rst (rst),
        .clr (cfg_we),
        .inc (1'b1),
        .cnt (time_cnt)
    );

    always_comb begin
        unique case (rd_sel_e'(rd_addr))
            RD_CNT0: rd_data = DATA_W'(cnt[0]);
            RD_CNT1: rd_data = DATA_W'(cnt[1]);
            RD_TIME: rd_data = DATA_W'(time_cnt);
            default: rd_data = {cfg_q[1], cfg_q[0]};
        endcase
    end

    // R6
    time_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_we && !$past(rst)) |=> time_cnt != $past(time_cnt));
endmodule

// File: tb/perf_counters_test.sv
module perf_counters_test;
    import perfctr_pkg::*;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 4;

    logic              clk = 0;
    logic              rst = 1;
    logic [EVT_N-1:0]  ev_pulse = '0;
    logic [ID_W-1:0]   ev_conn_id = '0;
    logic [RGN_W-1:0]  ev_region = '0;
    logic              cfg_we = 0;
    logic [31:0]       cfg_wdata = '0;
    logic [1:0]        rd_addr = '0;
    logic [31:0]       rd_data, rd_data_n;

    int compared = 0, mismatched = 0;
    string req = "R1";
    logic [31:0] m_cnt [2];
    logic [31:0] m_time, m_cfg;

    always #(CLK_PERIOD/2) clk = ~clk;

    perf_counters uut (.clk, .rst, .ev_pulse, .ev_conn_id, .ev_region, .cfg_we,
                       .cfg_wdata, .rd_addr, .rd_data);
    perf_counters #(.CNT_W(NW)) uut_n (.clk, .rst, .ev_pulse, .ev_conn_id, .ev_region,
                       .cfg_we, .cfg_wdata, .rd_addr, .rd_data(rd_data_n));

    function automatic logic m_hit(input logic [15:0] f);
        int code = int'(f[3:0]);
        if (code > 10) return 1'b0;
        if (!ev_pulse[code]) return 1'b0;
        if (f[4] && ev_conn_id != f[15:8]) return 1'b0;
        if (f[5] && ev_region != f[7:6]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        logic [31:0] exp [4];
        exp[0] = m_cnt[0]; exp[1] = m_cnt[1]; exp[2] = m_time; exp[3] = m_cfg;
        for (int a = 0; a < 4; a++) begin
            rd_addr = 2'(a);
            #1;
            check(rd_data, exp[a], $sformatf("addr %0d (R9)", a));
            check(rd_data_n, (a == 3) ? exp[a] : (exp[a] & 32'hF), $sformatf("narrow addr %0d (R8)", a));
        end
    endtask

    // one clock: model update from the inputs held across the edge, then compare at negedge
    task automatic tick();
        @(posedge clk);
        if (rst) begin
            m_cnt[0] = 0; m_cnt[1] = 0; m_time = 0; m_cfg = 0;
        end else if (cfg_we) begin
            m_cnt[0] = 0; m_cnt[1] = 0; m_time = 0; m_cfg = cfg_wdata;
        end else begin
            for (int c = 0; c < 2; c++)
                if (m_hit(c == 0 ? m_cfg[15:0] : m_cfg[31:16])) m_cnt[c] += 1;
            m_time += 1;
        end
        @(negedge clk);
        compare_all();
    endtask

    task automatic write_cfg(input logic [31:0] w);
        cfg_we = 1; cfg_wdata = w;
        ev_pulse = '1;  // R7: events in the write cycle are not counted
        tick();
        cfg_we = 0; ev_pulse = '0;
    endtask

    task automatic run(input int n, input logic [7:0] id_mask, input logic [1:0] rgn_mask);
        for (int i = 0; i < n; i++) begin
            ev_pulse   = EVT_N'($urandom);
            ev_conn_id = 8'($urandom) & id_mask;
            ev_region  = 2'($urandom) & rgn_mask;
            tick();
        end
        ev_pulse = '0;
    endtask

    initial begin
        m_cnt[0] = 0; m_cnt[1] = 0; m_time = 0; m_cfg = 0;
        @(negedge clk);
        req = "R1"; tick(); tick();
        rst = 0;
        req = "R6"; tick(); tick();
        req = "R2"; write_cfg({16'h0003, 16'h0002}); run(60, 8'hFF, 2'h3);
        write_cfg({16'h000A, 16'h0000}); run(60, 8'hFF, 2'h3);
        write_cfg({16'h0008, 16'h0005}); run(40, 8'hFF, 2'h3);
        write_cfg({16'h000F, 16'h000B}); ev_pulse = '1; tick(); tick(); run(30, 8'hFF, 2'h3);
        req = "R3"; write_cfg({16'h0000, 16'h5311}); run(80, 8'h03, 2'h3);
        write_cfg({16'h2011, 16'h0011}); run(80, 8'h20, 2'h3);
        req = "R4"; write_cfg({16'h00A1, 16'h0061}); run(80, 8'hFF, 2'h3);
        req = "R5"; write_cfg({16'h01F1, 16'h02B1}); run(120, 8'h03, 2'h3);
        req = "R7"; write_cfg({16'h0001, 16'h0004}); run(10, 8'hFF, 2'h3); write_cfg(32'h0000_0000); run(5, 8'hFF, 2'h3);
        req = "R8"; write_cfg({16'h0000, 16'h0000}); ev_pulse = '1;
        for (int i = 0; i < 40; i++) tick();
        ev_pulse = '0;
        req = "R1"; rst = 1; tick(); rst = 0; tick();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        mismatched++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule